// File: doc/BRIEF.md
# Data Start Block Resolver

After coarse time and frequency alignment of a chirp-modulated frame, the receiver holds the spectral magnitude found at the down-chirp bin for each of M consecutive sample blocks. This block works out which of those blocks marks where the payload begins. It needs no extra transforms to do this. It builds, from the integer symbol timing offset, how many down-chirp samples each block should hold. It then normalizes the measured magnitudes against a noise floor taken from the first two blocks. Finally, it slides the expected occupancy over the normalized measurements and reports the lag with the strongest match.

A one-cycle `start_i` pulse captures the offset and all M magnitudes and launches one resolution. The quotients are produced one after another by a bit-serial divider. The lag scores are then formed one lag per cycle. A one-cycle `done_o` pulse presents the winning index on `blk_o`, and that value holds until the next result. Computing and storing the transforms lies outside the block.

Top module: `dsb_resolver`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and `blk_o` is 0 until the first resolution completes.
- R2: With N = 2^LOG2N and offset S, the expected occupancy has slot 2 = N−S, slot 3 = N, slot 4 = N/4+S, and slot 5 = S−3N/4 when S > 3N/4 (0 otherwise). Every other slot is 0, and slots at or beyond M do not exist.
- R3: The noise floor is the larger of magnitudes 0 and 1. The spread is |m1 − m0|, and a spread of 0 is replaced by 1.
- R4: For slots 2..M−1, the normalized value is floor((m[k] − floor)·2^FRAC / spread). A magnitude at or below the floor gives 0, and slots 0 and 1 are 0.
- R5: The score of lag L is Σ e[j]·n[j+L], summed over the j with j+L < M, for L = 0..M−1.
- R6: `blk_o` is the lag with the highest score. On equal scores the lowest lag wins, so all-zero scores give 0. The value is always below M.
- R7: `done_o` is a one-cycle pulse. Let S be the clock edge that samples `start_i`. The pulse appears (M−2)·(MAG_W+FRAC+2)+M edges after S, and `blk_o` changes only together with it.
- R8: A `start_i` pulse that arrives while a resolution is in progress is ignored. Neither the result nor its timing changes.
- R9: Each quotient is exact: q·spread ≤ numerator < (q+1)·spread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle launch pulse |
| sto_i | input | LOG2N | Integer symbol timing offset in samples |
| mag_i | input | M·MAG_W | Down-chirp bin magnitudes, block k at bits k·MAG_W upward |
| done_o | output | 1 | One-cycle result pulse |
| blk_o | output | $clog2(M) | Resolved data start index |

## Verification
The bench uses the default build: N = 128, six blocks, 12-bit magnitudes and 8 fractional bits. This gives 20-bit quotients and a 94-cycle resolution. With these values, all four non-zero occupancy slots are exercised. Offsets above 96 bring the fourth slot into play, and a zero spread drives the largest possible quotient. Ties, magnitudes entirely below the floor, a start pulse during a busy run and pseudo-random magnitudes are each compared cycle by cycle against a behavioural model.

// File: rtl/dsb_pkg.sv
// Shared types for the data start block resolver.
package dsb_pkg;
    // Control states of the resolver sequencer.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIVGO   = 2'd1,
        ST_DIVWAIT = 2'd2,
        ST_CORR    = 2'd3
    } dsb_state_e;
endpackage

// File: rtl/dsb_expect.sv
// Expected down-chirp sample count per block, derived from the integer
// timing offset. Purely combinational. Assumes M >= 3; slots past M-1 drop out.
module dsb_expect #(
    parameter int LOG2N = 7,
    parameter int M     = 6,
    parameter int EW    = LOG2N + 2
) (
    input  logic [LOG2N-1:0] sto,
    output logic [M*EW-1:0]  exp_flat
);
    localparam int N = 1 << LOG2N;

    logic [EW-1:0] sto_w;
    logic [EW-1:0] e2, e3, e4, e5;

    // Occupancy of the four slots around the down-chirp tail.
    always_comb begin
        sto_w = EW'(sto);
        e2 = EW'(N) - sto_w;
        e3 = EW'(N);
        e4 = EW'(N / 4) + sto_w;
        e5 = (sto_w > EW'(3 * N / 4)) ? (sto_w - EW'(3 * N / 4)) : '0;
    end

    for (genvar j = 0; j < M; j++) begin : g_slot
        if (j == 2) begin : g_s2
            assign exp_flat[j*EW +: EW] = e2;
        end else if (j == 3) begin : g_s3
            assign exp_flat[j*EW +: EW] = e3;
        end else if (j == 4) begin : g_s4
            assign exp_flat[j*EW +: EW] = e4;
        end else if (j == 5) begin : g_s5
            assign exp_flat[j*EW +: EW] = e5;
        end else begin : g_zero
            assign exp_flat[j*EW +: EW] = '0;
        end
    end
endmodule

// File: rtl/dsb_divider.sv
// Restoring bit-serial unsigned divider: one quotient bit per clock, NW steps.
// Assumes den is non-zero and held stable while busy.
module dsb_divider #(
    parameter int NW = 20,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [NW-1:0] qsh;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          ge;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem, qsh[NW-1]};
        diff  = trial - {1'b0, den};
        ge    = (trial >= {1'b0, den});
    end

    // Shift-and-subtract iteration with a done pulse after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            qsh  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem  <= '0;
                qsh  <= num;
                cnt  <= CW'(NW);
                busy <= 1'b1;
            end else if (busy) begin
                rem <= ge ? diff[DW-1:0] : trial[DW-1:0];
                qsh <= {qsh[NW-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = qsh;
endmodule

// File: rtl/dsb_lagmac.sv
// Score of one alignment lag: sum of expected x normalized over overlapping slots.
// Combinational; M multipliers, one lag evaluated per call.
module dsb_lagmac #(
    parameter int M  = 6,
    parameter int EW = 9,
    parameter int QW = 20,
    parameter int LW = 3,
    parameter int SW = 33
) (
    input  logic [M*EW-1:0] exp_flat,
    input  logic [M*QW-1:0] nq_flat,
    input  logic [LW-1:0]   lag,
    output logic [SW-1:0]   score
);
    logic [EW+QW-1:0] prod;

    // Multiply-accumulate over slots j with j+lag inside the window.
    always_comb begin
        score = '0;
        prod  = '0;
        for (int j = 0; j < M; j++) begin
            if (j + int'(lag) < M) begin
                prod  = (EW+QW)'(exp_flat[j*EW +: EW]) * (EW+QW)'(nq_flat[(j + int'(lag))*QW +: QW]);
                score = score + SW'(prod);
            end
        end
    end
endmodule

// File: rtl/dsb_resolver.sv
// Data start block resolver top. Captures offset and M magnitudes on start,
// normalizes slots 2..M-1 through a serial divider, scores lags 0..M-1 and
// pulses done with the best lag (lowest on ties). Assumes M >= 3.
module dsb_resolver #(
    parameter int LOG2N = 7,
    parameter int M     = 6,
    parameter int MAG_W = 12,
    parameter int FRAC  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [LOG2N-1:0]       sto_i,
    input  logic [M*MAG_W-1:0]     mag_i,
    output logic                   done_o,
    output logic [$clog2(M)-1:0]   blk_o
);
    import dsb_pkg::*;

    localparam int EW = LOG2N + 2;
    localparam int QW = MAG_W + FRAC;
    localparam int LW = $clog2(M);
    localparam int SW = EW + QW + $clog2(M) + 1;

    dsb_state_e        state;
    logic [M*MAG_W-1:0] mag_q;
    logic [LOG2N-1:0]  sto_q;
    logic [MAG_W-1:0]  floor_q;
    logic [MAG_W-1:0]  range_q;
    logic [M*QW-1:0]   nq;
    logic [LW-1:0]     kidx;
    logic [LW-1:0]     lag;
    logic [SW-1:0]     best;
    logic [LW-1:0]     bidx;

    logic [MAG_W-1:0]  m0, m1, floor_c, spread_c, mk;
    logic [QW-1:0]     div_num;
    logic              div_go, div_done;
    logic [QW-1:0]     div_quo;
    logic [M*EW-1:0]   exp_flat;
    logic [SW-1:0]     score;

    // Noise floor and spread from the two leading blocks.
    always_comb begin
        m0       = mag_i[0 +: MAG_W];
        m1       = mag_i[MAG_W +: MAG_W];
        floor_c  = (m0 > m1) ? m0 : m1;
        spread_c = (m0 > m1) ? (m0 - m1) : (m1 - m0);
        if (spread_c == '0) spread_c = MAG_W'(1);
    end

    // Clamped, fixed-point-scaled numerator of the current slot.
    always_comb begin
        mk      = mag_q[int'(kidx)*MAG_W +: MAG_W];
        div_num = (mk > floor_q) ? {mk - floor_q, {FRAC{1'b0}}} : '0;
        div_go  = (state == ST_DIVGO);
    end

    dsb_expect #(.LOG2N(LOG2N), .M(M), .EW(EW)) u_exp (
        .sto      (sto_q),
        .exp_flat (exp_flat)
    );

    dsb_divider #(.NW(QW), .DW(MAG_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (range_q),
        .done  (div_done),
        .quo   (div_quo)
    );

    dsb_lagmac #(.M(M), .EW(EW), .QW(QW), .LW(LW), .SW(SW)) u_mac (
        .exp_flat (exp_flat),
        .nq_flat  (nq),
        .lag      (lag),
        .score    (score)
    );

    // Sequencer: capture, divide each slot, score each lag, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mag_q   <= '0;
            sto_q   <= '0;
            floor_q <= '0;
            range_q <= MAG_W'(1);
            nq      <= '0;
            kidx    <= '0;
            lag     <= '0;
            best    <= '0;
            bidx    <= '0;
            done_o  <= 1'b0;
            blk_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        mag_q   <= mag_i;
                        sto_q   <= sto_i;
                        floor_q <= floor_c;
                        range_q <= spread_c;
                        nq      <= '0;
                        kidx    <= LW'(2);
                        state   <= ST_DIVGO;
                    end
                end
                ST_DIVGO: begin
                    state <= ST_DIVWAIT;
                end
                ST_DIVWAIT: begin
                    if (div_done) begin
                        nq[int'(kidx)*QW +: QW] <= div_quo;
                        if (kidx == LW'(M - 1)) begin
                            lag   <= '0;
                            best  <= '0;
                            state <= ST_CORR;
                        end else begin
                            kidx  <= kidx + 1'b1;
                            state <= ST_DIVGO;
                        end
                    end
                end
                ST_CORR: begin
                    if (lag == '0 || score > best) begin
                        best <= score;
                        bidx <= lag;
                    end
                    if (lag == LW'(M - 1)) begin
                        done_o <= 1'b1;
                        blk_o  <= (score > best) ? lag : bidx;
                        state  <= ST_IDLE;
                    end else begin
                        lag <= lag + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsb_checker.sv
// Temporal checks on the resolver, attached by bind.
module dsb_checker #(
    parameter int M  = 6,
    parameter int QW = 20,
    parameter int DW = 12,
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [LW-1:0] blk_o,
    input logic          busy,
    input logic          div_done,
    input logic [QW-1:0] div_num,
    input logic [DW-1:0] div_den,
    input logic [QW-1:0] div_quo
);
    localparam int PW = QW + DW + 2;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R7
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy);

    // R7
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk_o) |-> done_o);

    // R6
    blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(blk_o) < M));

    // R9
    quo_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> ((PW'(div_quo) * PW'(div_den) <= PW'(div_num)) &&
                      (PW'(div_num) < (PW'(div_quo) + PW'(1)) * PW'(div_den))));
endmodule

bind dsb_resolver dsb_checker #(.M(M), .QW(QW), .DW(MAG_W), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .blk_o    (blk_o),
    .busy     (state != dsb_pkg::ST_IDLE),
    .div_done (div_done),
    .div_num  (div_num),
    .div_den  (range_q),
    .div_quo  (div_quo)
);

// File: tb/sim_dsb_resolver.sv
`timescale 1ns/1ps
module sim_dsb_resolver;
    localparam int LOG2N = 7;
    localparam int M     = 6;
    localparam int MAG_W = 12;
    localparam int FRAC  = 8;
    localparam int N     = 1 << LOG2N;
    localparam int LW    = $clog2(M);
    localparam int LAT   = (M - 2) * (MAG_W + FRAC + 2) + M;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [LOG2N-1:0]     sto_i = '0;
    logic [M*MAG_W-1:0]   mag_i = '0;
    logic                 done_o;
    logic [LW-1:0]        blk_o;

    int n_cmp = 0;
    int n_bad = 0;
    int mv[M];
    int unsigned lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    dsb_resolver #(.LOG2N(LOG2N), .M(M), .MAG_W(MAG_W), .FRAC(FRAC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sto_i(sto_i),
        .mag_i(mag_i), .done_o(done_o), .blk_o(blk_o));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: expected slot, normalization, lag scores, argmax.
    function automatic int ref_blk(input int sto);
        longint e[M];
        longint nv[M];
        longint sc, bsc;
        int fl, rg, bi;
        fl = (mv[0] > mv[1]) ? mv[0] : mv[1];
        rg = (mv[0] > mv[1]) ? mv[0] - mv[1] : mv[1] - mv[0];
        if (rg == 0) rg = 1;
        for (int j = 0; j < M; j++) begin
            e[j] = 0;
            if (j == 2) e[j] = N - sto;
            if (j == 3) e[j] = N;
            if (j == 4) e[j] = N / 4 + sto;
            if (j == 5) e[j] = (sto > 3 * N / 4) ? sto - 3 * N / 4 : 0;
            nv[j] = (j >= 2 && mv[j] > fl) ? ((longint'(mv[j] - fl) * 256) / rg) : 0;
        end
        bsc = -1;
        bi = 0;
        for (int l = 0; l < M; l++) begin
            sc = 0;
            for (int j = 0; j + l < M; j++) sc += e[j] * nv[j + l];
            if (sc > bsc) begin
                bsc = sc;
                bi = l;
            end
        end
        return bi;
    endfunction

    function automatic int rnd(input int lim);
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'((lcg >> 8) % lim);
    endfunction

    // One resolution compared every clock; optional stray start mid-run (R8).
    task automatic run_case(input int sto, input string tag, input bit stray, input int force_exp);
        int exp_blk;
        exp_blk = ref_blk(sto);
        if (force_exp >= 0) check(exp_blk == force_exp, {tag, " R6 model"}, exp_blk, force_exp);
        @(negedge clk);
        for (int k = 0; k < M; k++) mag_i[k*MAG_W +: MAG_W] = MAG_W'(mv[k]);
        sto_i   = LOG2N'(sto);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, {tag, " R7 done early"}, done_o, 0);
        for (int c = 1; c <= LAT + 2; c++) begin
            if (stray && c == 20) begin
                start_i = 1'b1;
                mag_i   = {M{12'hABC}};
                sto_i   = LOG2N'(N - 1);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            check(done_o == (c == LAT), {tag, " R7 done timing"}, done_o, (c == LAT));
            if (c == LAT)
                check(int'(blk_o) == exp_blk, {tag, " R6 R5 R4 R3 R2 index"}, blk_o, exp_blk);
            if (c > LAT)
                check(int'(blk_o) == exp_blk, {tag, " R7 index hold"}, blk_o, exp_blk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check(done_o == 1'b0, "R1 done in reset", done_o, 0);
        check(blk_o == '0, "R1 blk in reset", blk_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0, "R1 done after reset", done_o, 0);
        check(blk_o == '0, "R1 blk after reset", blk_o, 0);

        // R2 R5: tail energy in slots 3,4 with zero offset
        mv = '{100, 110, 100, 1110, 1110, 100};
        run_case(0, "A", 1'b0, -1);
        // R2: energy early, expect lag 0
        mv = '{200, 190, 2000, 2100, 900, 150};
        run_case(0, "B", 1'b0, -1);
        // R2: large offset makes slot 5 non-zero
        mv = '{50, 70, 60, 80, 1500, 3000};
        run_case(120, "C", 1'b0, -1);
        // R3: zero spread forced to 1, largest quotients
        mv = '{50, 50, 4095, 4095, 4095, 4095};
        run_case(64, "D", 1'b0, -1);
        // R4 R6: everything at or below floor -> all scores 0 -> lowest lag
        mv = '{900, 1000, 10, 500, 1000, 0};
        run_case(10, "E", 1'b0, 0);
        // R6: only the last slot carries energy -> several lags tie at 0 beyond
        mv = '{0, 4, 0, 0, 0, 400};
        run_case(0, "F", 1'b0, -1);
        // R8: stray start while busy is ignored
        mv = '{300, 320, 330, 2500, 2600, 340};
        run_case(33, "G", 1'b1, -1);
        // R5 R6: pseudo-random magnitudes and offsets
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < M; k++) mv[k] = rnd(4096);
            run_case(rnd(N), "RND", (t % 4) == 3, -1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule